// File: doc/BRIEF.md
# Serial Ethernet Frame Transmitter

This block turns a frame held in a byte-wide buffer into a bit-serial Ethernet transmission. It sends one bit per transmit clock on a single data line and holds an active-high enable for the whole frame. The buffer supplies the addresses, the type/length field and the payload, in that order, over a valid/ready handshake. A last-byte marker ends the frame. The block adds everything else: the synchronisation header in front, zero padding when the frame is short, and the 32-bit check sequence at the end.

Before it starts, the block defers. Carrier sense is the OR of the receive-enable and collision inputs, and it must have been low for a full inter-frame gap. Once a frame is on the line, a collision replaces the rest of the frame with a jam pattern and ends the attempt with a collision flag. If the buffer has no byte ready when one is needed, the block stops at once with an underrun flag. Retry scheduling and descriptor handling belong to the host.

Top module: `eth_serial_tx`

## Requirements
- R1: While reset is high, `tx_en`, `txd`, `in_ready`, `frame_done`, `coll_abort` and `underrun_err` are all low.
- R2: A pending frame (`in_valid` high while idle) starts only after carrier sense (`rx_enable` OR `collision`) has been low on 96 consecutive clocks with the block idle. In the clock after such a start edge, `tx_en` is high.
- R3: Every frame opens with seven 0x55 bytes and then one 0xD5 byte, each sent least-significant bit first.
- R4: Buffer bytes go out in arrival order, least-significant bit first, with no gap after the header. `in_ready` is high only during the final bit of the 0xD5 byte and the final bit of each buffer byte that was not marked last. A byte transfers when `in_valid` and `in_ready` are both high.
- R5: When the frame has fewer than 60 buffer bytes (14 header bytes plus 46 payload bytes), zero bytes follow until 60 bytes have gone out.
- R6: After the last data or pad byte, 32 check bits are sent. They are the complement of a CRC-32 (generator 0x04C11DB7, processed in bit-reversed form as 0xEDB88320, register preset to all ones) computed over the buffer and pad bytes in line order. Register bit 0 is sent first.
- R7: `tx_en` stays high from the first header bit to the last check bit. In the next clock `tx_en` is low and `frame_done` is high for exactly one clock.
- R8: If `collision` is high in a clock while the header, data, pad or check bits are being sent, the next 32 bits are the jam pattern 1,0,1,0,... (0x55 bytes sent LSB first). The clock after the jam has `tx_en` low and `coll_abort` high for one clock. `in_ready` is low whenever `collision` is high and throughout the jam.
- R9: If `in_ready` is high while `in_valid` is low, the next clock has `tx_en` low and `underrun_err` high for one clock, and no check bits are sent.
- R10: `rx_enable` going high while a frame is being sent does not change any transmitted bit.
- R11: A frame of 60 or more buffer bytes gets no padding; the check bits follow the last buffer byte directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Buffer byte |
| in_valid | input | 1 | Buffer byte available |
| in_last | input | 1 | Current buffer byte ends the frame |
| in_ready | output | 1 | Block takes the byte this clock |
| rx_enable | input | 1 | Receive activity from the transceiver |
| collision | input | 1 | Collision indication from the transceiver |
| txd | output | 1 | Serial transmit data |
| tx_en | output | 1 | Transmit enable, active high |
| frame_done | output | 1 | One-clock pulse after a complete frame |
| coll_abort | output | 1 | One-clock pulse after a jam ends |
| underrun_err | output | 1 | One-clock pulse on a buffer underrun |

## Verification
The bench targets the pad boundary with frames of 59, 60 and 64 bytes. A design that counts the header into the pad limit wrongly, or pads one byte too many or too few, shifts every check bit that follows. Collisions are driven in the preamble, in the data and in the middle of the check bits. A design that finishes the current byte first, keeps `in_ready` up or reports completion would show up as wrong jam bits or a wrong flag. Underruns are forced at the very first data byte and in the middle of the frame, and a frame waits behind a busy carrier. Late or early starts and check bits sent after an underrun are caught on the exact clock where they happen.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_JAM
    } tx_state_e;

    typedef struct packed {
        logic done;
        logic coll;
        logic under;
    } tx_evt_t;

    localparam logic [7:0]  PRE_BYTE     = 8'h55;
    localparam logic [7:0]  SFD_BYTE     = 8'hD5;
    localparam logic [7:0]  JAM_BYTE     = 8'h55;
    localparam logic [7:0]  PAD_BYTE     = 8'h00;
    localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET   = 32'hFFFF_FFFF;

    // One bit of the reflected CRC-32 update.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return fb ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
    endfunction

    function automatic logic is_sending(input tx_state_e s);
        return (s == ST_PRE) || (s == ST_DATA) || (s == ST_PAD) || (s == ST_FCS);
    endfunction

endpackage

// File: rtl/eth_tx_defer.sv
module eth_tx_defer #(
    parameter int IFG_BITS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic rx_enable,
    input  logic collision,
    output logic gap_ok
);
    localparam int CW = $clog2(IFG_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(IFG_BITS);

    logic          carrier;
    logic [CW-1:0] quiet_q;

    assign carrier = rx_enable | collision;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
        end else if (!idle || carrier) begin
            quiet_q <= '0;
        end else if (quiet_q != FULL) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign gap_ok = idle && !carrier && (quiet_q == FULL);

    // R2
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        gap_ok |-> $past(idle && !carrier));

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic feed,
    input  logic drain,
    input  logic bit_in,
    output logic fcs_bit
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= CRC_PRESET;
        end else if (feed) begin
            crc_q <= crc32_step(crc_q, bit_in);
        end else if (drain) begin
            crc_q <= {1'b1, crc_q[31:1]};
        end
    end

    assign fcs_bit = ~crc_q[0];

    // R6
    feed_drain_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(feed && drain));

endmodule

// File: rtl/eth_tx_ser.sv
module eth_tx_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         bit_out,
    output logic         word_end
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_out  = sh_q[0];
    assign word_end = (cnt_q == BW'(W - 1));

    // R4
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/eth_serial_tx.sv
module eth_serial_tx
    import eth_tx_pkg::*;
#(
    parameter int IFG_BITS  = 96,
    parameter int PRE_BYTES = 7,
    parameter int MIN_BYTES = 60,
    parameter int JAM_BYTES = 4,
    parameter int LEN_W     = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       rx_enable,
    input  logic       collision,
    output logic       txd,
    output logic       tx_en,
    output logic       frame_done,
    output logic       coll_abort,
    output logic       underrun_err
);
    localparam int FCS_BYTES = 4;
    localparam int CNT_MAX   = (PRE_BYTES > JAM_BYTES) ? PRE_BYTES : JAM_BYTES;
    localparam int BYTE_W    = $clog2(CNT_MAX + 1);
    localparam logic [BYTE_W-1:0] SFD_IDX  = BYTE_W'(PRE_BYTES);
    localparam logic [BYTE_W-1:0] LAST_PRE = BYTE_W'(PRE_BYTES - 1);
    localparam logic [BYTE_W-1:0] LAST_FCS = BYTE_W'(FCS_BYTES - 1);
    localparam logic [BYTE_W-1:0] LAST_JAM = BYTE_W'(JAM_BYTES - 1);
    localparam logic [LEN_W-1:0]  MIN_LEN  = LEN_W'(MIN_BYTES);

    tx_state_e          state_q, state_d;
    logic [BYTE_W-1:0]  byte_q, byte_d;
    logic [LEN_W-1:0]   len_q, len_d, len_inc;
    logic               last_q, last_d;
    tx_evt_t            evt_q, evt_d;

    logic       ld, sh, wend, ser_bit;
    logic [7:0] ld_val;
    logic       crc_init, crc_feed, crc_drain, fcs_bit;
    logic       gap_ok, rdy, go_jam;

    eth_tx_defer #(.IFG_BITS(IFG_BITS)) defer_i (
        .clk       (clk),
        .rst       (rst),
        .idle      (state_q == ST_IDLE),
        .rx_enable (rx_enable),
        .collision (collision),
        .gap_ok    (gap_ok)
    );

    eth_tx_ser #(.W(8)) ser_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .shift    (sh),
        .bit_out  (ser_bit),
        .word_end (wend)
    );

    eth_tx_crc crc_i (
        .clk     (clk),
        .rst     (rst),
        .init    (crc_init),
        .feed    (crc_feed),
        .drain   (crc_drain),
        .bit_in  (ser_bit),
        .fcs_bit (fcs_bit)
    );

    assign len_inc = (len_q == '1) ? len_q : len_q + 1'b1;
    assign go_jam  = collision && is_sending(state_q);

    always_comb begin
        state_d   = state_q;
        byte_d    = byte_q;
        len_d     = len_q;
        last_d    = last_q;
        evt_d     = '0;
        ld        = 1'b0;
        ld_val    = PAD_BYTE;
        sh        = 1'b0;
        crc_init  = 1'b0;
        crc_feed  = 1'b0;
        crc_drain = 1'b0;
        rdy       = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (in_valid && gap_ok) begin
                    state_d  = ST_PRE;
                    ld       = 1'b1;
                    ld_val   = PRE_BYTE;
                    byte_d   = '0;
                    crc_init = 1'b1;
                end
            end
            ST_PRE: begin
                if (!wend) begin
                    sh = 1'b1;
                end else if (byte_q == SFD_IDX) begin
                    rdy = 1'b1;
                    if (in_valid) begin
                        state_d = ST_DATA;
                        ld      = 1'b1;
                        ld_val  = in_data;
                        len_d   = LEN_W'(1);
                        last_d  = in_last;
                    end else begin
                        state_d   = ST_IDLE;
                        evt_d.under = 1'b1;
                    end
                end else begin
                    ld     = 1'b1;
                    ld_val = (byte_q == LAST_PRE) ? SFD_BYTE : PRE_BYTE;
                    byte_d = byte_q + 1'b1;
                end
            end
            ST_DATA: begin
                crc_feed = 1'b1;
                if (!wend) begin
                    sh = 1'b1;
                end else if (last_q) begin
                    ld     = 1'b1;
                    ld_val = PAD_BYTE;
                    byte_d = '0;
                    if (len_q < MIN_LEN) begin
                        state_d = ST_PAD;
                        len_d   = len_inc;
                    end else begin
                        state_d = ST_FCS;
                    end
                end else begin
                    rdy = 1'b1;
                    if (in_valid) begin
                        ld     = 1'b1;
                        ld_val = in_data;
                        len_d  = len_inc;
                        last_d = in_last;
                    end else begin
                        state_d     = ST_IDLE;
                        evt_d.under = 1'b1;
                    end
                end
            end
            ST_PAD: begin
                crc_feed = 1'b1;
                if (!wend) begin
                    sh = 1'b1;
                end else begin
                    ld     = 1'b1;
                    ld_val = PAD_BYTE;
                    if (len_q >= MIN_LEN) begin
                        state_d = ST_FCS;
                        byte_d  = '0;
                    end else begin
                        len_d = len_inc;
                    end
                end
            end
            ST_FCS: begin
                crc_drain = 1'b1;
                if (!wend) begin
                    sh = 1'b1;
                end else if (byte_q == LAST_FCS) begin
                    state_d    = ST_IDLE;
                    evt_d.done = 1'b1;
                end else begin
                    ld     = 1'b1;
                    byte_d = byte_q + 1'b1;
                end
            end
            ST_JAM: begin
                if (!wend) begin
                    sh = 1'b1;
                end else if (byte_q == LAST_JAM) begin
                    state_d    = ST_IDLE;
                    evt_d.coll = 1'b1;
                end else begin
                    ld     = 1'b1;
                    ld_val = JAM_BYTE;
                    byte_d = byte_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (go_jam) begin
            state_d = ST_JAM;
            ld      = 1'b1;
            ld_val  = JAM_BYTE;
            sh      = 1'b0;
            byte_d  = '0;
            rdy     = 1'b0;
            evt_d   = '0;
            len_d   = len_q;
            last_d  = last_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            len_q   <= '0;
            last_q  <= 1'b0;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            len_q   <= len_d;
            last_q  <= last_d;
            evt_q   <= evt_d;
        end
    end

    assign in_ready     = rdy;
    assign tx_en        = (state_q != ST_IDLE);
    assign txd          = (state_q == ST_FCS)  ? fcs_bit :
                          (state_q == ST_IDLE) ? 1'b0 : ser_bit;
    assign frame_done   = evt_q.done;
    assign coll_abort   = evt_q.coll;
    assign underrun_err = evt_q.under;

    // R7
    evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_done, coll_abort, underrun_err}));

    // R7
    end_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done || coll_abort || underrun_err) |-> (!tx_en && $past(tx_en)));

    // R2
    start_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(gap_ok));

    // R4
    ready_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_en);

    // R8
    jam_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JAM) |=> (state_q == ST_JAM || coll_abort));

endmodule

// File: tb/eth_serial_tx_tb_top.sv
module eth_serial_tx_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic       rx_enable = 1'b0, collision = 1'b0;
    logic       txd, tx_en, frame_done, coll_abort, underrun_err;

    eth_serial_tx dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .rx_enable(rx_enable),
        .collision(collision), .txd(txd), .tx_en(tx_en),
        .frame_done(frame_done), .coll_abort(coll_abort),
        .underrun_err(underrun_err)
    );

    int vectors = 0, fails = 0;
    bit finished = 0;

    logic [7:0] fr[$];
    int rd = 0, gap_at = -1, nbytes = 0;
    bit loaded = 0;

    bit m_tx = 0, m_jam = 0, m_und = 0;
    int m_pos = 0, quiet = 0;
    bit sq[$];
    string tq[$];
    string cur_tag = "R2";
    logic e_en = 0, e_d = 0, e_done = 0, e_col = 0, e_und = 0;

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_byte(input logic [7:0] v, input string tag, input bit use_crc,
                             inout logic [31:0] c);
        for (int k = 0; k < 8; k++) begin
            bit b = v[k];
            sq.push_back(b);
            tq.push_back(tag);
            if (use_crc) c = (c[0] ^ b) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
    endtask

    task automatic build_stream();
        logic [31:0] c = 32'hFFFF_FFFF;
        int lim;
        string dtag;
        sq.delete();
        tq.delete();
        nbytes = fr.size();
        dtag = (nbytes >= 60) ? "R11" : "R4";
        for (int i = 0; i < 8; i++) push_byte((i < 7) ? 8'h55 : 8'hD5, "R3", 0, c);
        lim = (gap_at >= 0) ? gap_at : nbytes;
        for (int i = 0; i < lim; i++) push_byte(fr[i], dtag, 1, c);
        if (gap_at < 0) begin
            for (int i = nbytes; i < 60; i++) push_byte(8'h00, "R5", 1, c);
            for (int k = 0; k < 32; k++) begin
                sq.push_back(~c[k]);
                tq.push_back("R6");
            end
        end
        m_und = (gap_at >= 0);
    endtask

    function automatic bit exp_ready();
        if (!m_tx || m_jam || collision) return 0;
        if (m_pos == 63) return 1;
        if (m_pos >= 64 && ((m_pos - 64) % 8) == 7 && ((m_pos - 64) / 8) < nbytes - 1) return 1;
        return 0;
    endfunction

    task automatic model_step();
        bit cs = rx_enable | collision;
        e_done = 0; e_col = 0; e_und = 0;
        if (m_tx) begin
            quiet = 0;
            if (collision && !m_jam) begin
                m_jam = 1;
                sq.delete();
                tq.delete();
                for (int k = 0; k < 32; k++) begin
                    sq.push_back((k % 2) == 0);
                    tq.push_back("R8");
                end
            end
            if (sq.size() == 0) begin
                m_tx = 0; e_en = 0; e_d = 0;
                if (m_jam) begin e_col = 1; cur_tag = "R8"; end
                else if (m_und) begin e_und = 1; cur_tag = "R9"; end
                else begin e_done = 1; cur_tag = "R7"; end
            end else begin
                e_d = sq.pop_front();
                cur_tag = tq.pop_front();
                e_en = 1;
                m_pos++;
                if (rx_enable && !m_jam) cur_tag = "R10";
            end
        end else begin
            if (in_valid && quiet == 96 && !cs) begin
                build_stream();
                m_tx = 1; m_jam = 0; m_pos = 0;
                e_d = sq.pop_front();
                cur_tag = tq.pop_front();
                e_en = 1;
            end else begin
                e_en = 0; e_d = 0; cur_tag = "R2";
            end
            quiet = cs ? 0 : ((quiet < 96) ? quiet + 1 : 96);
        end
    endtask

    task automatic drive_feed();
        in_valid = loaded && (rd < fr.size()) && (rd != gap_at);
        in_data  = in_valid ? fr[rd] : 8'h00;
        in_last  = in_valid && (rd == fr.size() - 1);
    endtask

    task automatic tick();
        drive_feed();
        @(negedge clk);
        check(collision ? "R8" : "R4", "in_ready", in_ready, exp_ready());
        if (in_valid && in_ready) rd++;
        model_step();
        @(posedge clk);
        #1;
        check(cur_tag, "tx_en", tx_en, e_en);
        check(cur_tag, "txd", txd, e_d);
        check("R7", "frame_done", frame_done, e_done);
        check("R8", "coll_abort", coll_abort, e_col);
        check("R9", "underrun_err", underrun_err, e_und);
    endtask

    task automatic send(input int n, input int seed, input int gap, input int col_pos,
                        input int busy, input bit rx_mid);
        int t = 0;
        bit started = 0;
        fr.delete();
        for (int i = 0; i < n; i++) fr.push_back(8'(seed * 37 + i * 13 + (i >> 2)));
        rd = 0; gap_at = gap; loaded = 1;
        while (1) begin
            rx_enable = (t < busy) || (rx_mid && m_tx && m_pos > 100 && m_pos < 200);
            collision = (col_pos >= 0) && m_tx && !m_jam && (m_pos == col_pos);
            tick();
            t++;
            if (m_tx) started = 1;
            if ((started && !m_tx) || t > 5000) break;
        end
        loaded = 0; rx_enable = 0; collision = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: everything quiet during reset
        check("R1", "tx_en", tx_en, 1'b0);
        check("R1", "txd", txd, 1'b0);
        check("R1", "in_ready", in_ready, 1'b0);
        check("R1", "frame_done", frame_done, 1'b0);
        check("R1", "coll_abort", coll_abort, 1'b0);
        check("R1", "underrun_err", underrun_err, 1'b0);
        rst = 1'b0;
        send(20, 1, -1, -1, 0, 0);    // R5 pad to minimum
        send(64, 2, -1, -1, 40, 1);   // R2 defer behind carrier, R10, R11
        send(60, 3, -1, -1, 0, 0);    // R11 exact minimum
        send(59, 4, -1, -1, 0, 0);    // R5 one pad byte
        send(30, 5, -1, 150, 0, 0);   // R8 collision in data
        send(10, 6, -1, 20, 0, 0);    // R8 collision in preamble
        send(25, 7, 5, -1, 0, 0);     // R9 underrun mid-frame
        send(25, 8, 0, -1, 0, 0);     // R9 underrun at first byte
        send(46, 9, -1, 554, 0, 0);   // R8 collision in check bits
        send(14, 10, -1, -1, 3, 0);   // R5 header only, R2
        repeat (20) tick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL R2 watchdog: actual running expected finished at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule